// File: doc/BRIEF.md
# Byte-Wide Bidirectional GPIO Port

This block is an 8-bit general-purpose I/O port that sits on a simple byte-wide register bus. Three registers control it. The output latch holds the level that each pin drives. The direction register decides which pins drive and which only listen. The input-enable register decides which listening pins are passed on to an internal peripheral. Each pad has its own output value, output enable and input value. The output enable of a bit is its direction bit.

Pin levels pass through a two-stage synchronizer before anything inside uses them. A normal read of the data address returns these synchronized pin levels, not the latch. For a driven bit the two agree; for an input bit the latch cannot be seen. Set-bit and clear-bit operations work on the latch itself. They change one addressed bit and leave every other latch bit as it was, even where the external level on an input pin differs. A bit reaches the peripheral only when it is an input and its input-enable bit is 1. Otherwise that peripheral input is held at 0.

Top module: `gpio_byte_port`

## Requirements
- R1: After reset the direction register and the input-enable register read 0, `pad_oe` is all zeros and `periph_in` is all zeros. The output latch has no defined reset value.
- R2: A normal write (`bus_op` = 2'b00) to address 0x26 loads the direction register at the clock edge. From then on `pad_oe` equals it: bit = 1 drives the pin, bit = 0 releases it.
- R3: A normal write to address 0x25 loads the output latch at the clock edge, and `pad_out` presents the latch on the next cycle.
- R4: A read with `bus_rd` = 1 at address 0x25 returns the pin levels through a two-flop synchronizer, in the same cycle as the read. A change on `pad_in` shows in the read data after exactly two rising clock edges.
- R5: A write with `bus_op` = 2'b01 at address 0x25 sets latch bit `bus_bit` and leaves every other latch bit unchanged, whatever the pin levels are.
- R6: A write with `bus_op` = 2'b10 at address 0x25 clears latch bit `bus_bit` and leaves every other latch bit unchanged, whatever the pin levels are.
- R7: Reads at address 0x26 return the direction register and reads at address 0x27 return the input-enable register. A normal write to 0x27 loads the input-enable register.
- R8: `periph_in[i]` equals the synchronized level of pin i when direction bit i is 0 and input-enable bit i is 1. In every other case it is 0.
- R9: Writes with `bus_op` = 2'b11 change no register. Writes to addresses other than 0x25..0x27 change no register. Reads of other addresses return 0. `bus_rdata` is 0 whenever `bus_rd` is 0.
- R10: Set-bit and clear-bit operations addressed to 0x26 or 0x27 change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data for normal writes |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_op | input | 2 | Write operation: 00 normal, 01 set bit, 10 clear bit, 11 reserved |
| bus_bit | input | 3 | Bit index for set-bit and clear-bit |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Read data, valid in the cycle of `bus_rd` |
| pad_out | output | 8 | Output latch value presented to the pads |
| pad_oe | output | 8 | Per-bit pad driver enable |
| pad_in | input | 8 | Levels seen on the pads |
| periph_in | output | 8 | Gated pin levels for the internal peripheral |

## Verification
The bench models each pad as a resolved pin. A driven bit takes `pad_out`. A released bit takes a bench-chosen external level, and that level is deliberately made to differ from the latch. Four corner cases get direct attention:

- **Bit operations on input pins.** The bench applies set-bit and clear-bit to every bit of many latch patterns while the pins read the inverse. A design that read the pins for these operations would corrupt the untouched bits.
- **Read data at the data address.** Sweeps over direction and data patterns check that the read returns the pins and not the latch. A design that returned the latch would give the wrong value on every input bit.
- **Synchronizer latency.** A single pin edge is timed cycle by cycle. One flop too few or too many moves the edge by a cycle.
- **Ignored accesses.** The peripheral gate is swept over direction and enable combinations. Reserved, unmapped and misdirected bit operations are all followed by read-back. A gate missing the direction term, or a decode that reacts to the reserved op code, shows up as a changed register.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  typedef enum logic [1:0] {
    OP_WRITE = 2'b00,
    OP_SET   = 2'b01,
    OP_CLEAR = 2'b10,
    OP_RSVD  = 2'b11
  } bus_op_e;

  // Read-modify-write of one latch bit; vectors up to 32 bits wide.
  function automatic logic [31:0] apply_bit_op(logic [31:0] cur, bus_op_e op, logic [4:0] idx);
    logic [31:0] mask;
    mask = 32'd1 << idx;
    case (op)
      OP_SET:   apply_bit_op = cur | mask;
      OP_CLEAR: apply_bit_op = cur & ~mask;
      default:  apply_bit_op = cur;
    endcase
  endfunction

  // A pin reaches the peripheral only as an enabled input.
  function automatic logic [31:0] gate_periph(logic [31:0] pins, logic [31:0] dir, logic [31:0] ien);
    gate_periph = pins & ~dir & ien;
  endfunction

endpackage

// File: rtl/gpio_bus_decode.sv
module gpio_bus_decode
  import gpio_port_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h26,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'h27
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [1:0]        op,
  output logic              hit_data,
  output logic              hit_dir,
  output logic              hit_ien,
  output logic              wr_data_norm,
  output logic              wr_set,
  output logic              wr_clr,
  output logic              wr_dir,
  output logic              wr_ien
);
  bus_op_e op_e;

  always_comb begin
    op_e         = bus_op_e'(op);
    hit_data     = (addr == DATA_ADDR);
    hit_dir      = (addr == DIR_ADDR);
    hit_ien      = (addr == IEN_ADDR);
    wr_data_norm = wr && hit_data && (op_e == OP_WRITE);
    wr_set       = wr && hit_data && (op_e == OP_SET);
    wr_clr       = wr && hit_data && (op_e == OP_CLEAR);
    wr_dir       = wr && hit_dir  && (op_e == OP_WRITE);
    wr_ien       = wr && hit_ien  && (op_e == OP_WRITE);
  end
endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
  import gpio_port_pkg::*;
#(
  parameter int WIDTH = 8,
  localparam int BIT_W = $clog2(WIDTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] wdata,
  input  logic [1:0]       op,
  input  logic [BIT_W-1:0] bit_idx,
  input  logic             wr_data_norm,
  input  logic             wr_set,
  input  logic             wr_clr,
  input  logic             wr_dir,
  input  logic             wr_ien,
  output logic [WIDTH-1:0] latch_q,
  output logic [WIDTH-1:0] dir_q,
  output logic [WIDTH-1:0] ien_q
);
  logic [WIDTH-1:0] bitop_next;

  always_comb begin
    bitop_next = WIDTH'(apply_bit_op(32'(latch_q), bus_op_e'(op), 5'(bit_idx)));
  end

  // The output latch has no reset: its power-up value is undefined.
  always_ff @(posedge clk) begin
    if (wr_data_norm)          latch_q <= wdata;
    else if (wr_set || wr_clr) latch_q <= bitop_next;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      ien_q <= '0;
    end else begin
      if (wr_dir) dir_q <= wdata;
      if (wr_ien) ien_q <= wdata;
    end
  end
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int WIDTH  = 8,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_in,
  output logic [WIDTH-1:0] sync_out
);
  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q[0] <= '0;
    else        stage_q[0] <= async_in;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[s] <= '0;
      else        stage_q[s] <= stage_q[s-1];
    end
  end

  assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_byte_port.sv
module gpio_byte_port
  import gpio_port_pkg::*;
#(
  parameter int WIDTH       = 8,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] DATA_ADDR = 8'h25,
  parameter logic [ADDR_W-1:0] DIR_ADDR  = 8'h26,
  parameter logic [ADDR_W-1:0] IEN_ADDR  = 8'h27,
  localparam int BIT_W = $clog2(WIDTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic              bus_wr,
  input  logic [1:0]        bus_op,
  input  logic [BIT_W-1:0]  bus_bit,
  input  logic              bus_rd,
  output logic [WIDTH-1:0]  bus_rdata,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  input  logic [WIDTH-1:0]  pad_in,
  output logic [WIDTH-1:0]  periph_in
);
  // Named internal events for the bound checker.
  logic hit_data, hit_dir, hit_ien;
  logic wr_data_norm, wr_set, wr_clr, wr_dir, wr_ien;
  logic [WIDTH-1:0] latch_q, dir_q, ien_q, pin_sync;

  gpio_bus_decode #(
    .ADDR_W(ADDR_W), .DATA_ADDR(DATA_ADDR), .DIR_ADDR(DIR_ADDR), .IEN_ADDR(IEN_ADDR)
  ) u_decode (
    .addr(bus_addr), .wr(bus_wr), .op(bus_op),
    .hit_data(hit_data), .hit_dir(hit_dir), .hit_ien(hit_ien),
    .wr_data_norm(wr_data_norm), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_dir(wr_dir), .wr_ien(wr_ien)
  );

  gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
    .clk(clk), .rst_n(rst_n), .wdata(bus_wdata), .op(bus_op), .bit_idx(bus_bit),
    .wr_data_norm(wr_data_norm), .wr_set(wr_set), .wr_clr(wr_clr),
    .wr_dir(wr_dir), .wr_ien(wr_ien),
    .latch_q(latch_q), .dir_q(dir_q), .ien_q(ien_q)
  );

  gpio_pin_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(pad_in), .sync_out(pin_sync)
  );

  always_comb begin
    pad_out   = latch_q;
    pad_oe    = dir_q;
    periph_in = WIDTH'(gate_periph(32'(pin_sync), 32'(dir_q), 32'(ien_q)));
    bus_rdata = '0;
    if (bus_rd) begin
      if (hit_data)     bus_rdata = pin_sync;
      else if (hit_dir) bus_rdata = dir_q;
      else if (hit_ien) bus_rdata = ien_q;
    end
  end
endmodule

// File: rtl/gpio_byte_port_checker.sv
module gpio_byte_port_checker #(
  parameter int WIDTH  = 8,
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] DIR_ADDR = 8'h26,
  parameter logic [ADDR_W-1:0] IEN_ADDR = 8'h27,
  localparam int BIT_W = $clog2(WIDTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [WIDTH-1:0]  bus_wdata,
  input logic              bus_wr,
  input logic [1:0]        bus_op,
  input logic [BIT_W-1:0]  bus_bit,
  input logic              bus_rd,
  input logic [WIDTH-1:0]  bus_rdata,
  input logic [WIDTH-1:0]  pad_out,
  input logic [WIDTH-1:0]  pad_oe,
  input logic [WIDTH-1:0]  periph_in,
  input logic              wr_data_norm,
  input logic              wr_set,
  input logic              wr_clr,
  input logic              wr_dir,
  input logic              wr_ien
);
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  assert_oe_clear_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (pad_oe == '0 && periph_in == '0));

  assert_dir_drives_oe_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_dir |=> pad_oe == $past(bus_wdata));

  assert_latch_to_pad_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_data_norm |=> pad_out == $past(bus_wdata));

  assert_set_one_bit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_set |=> pad_out == ($past(pad_out) | (ONE << $past(bus_bit))));

  assert_clear_one_bit_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clr |=> pad_out == ($past(pad_out) & ~(ONE << $past(bus_bit))));

  assert_dir_readback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == DIR_ADDR) |-> bus_rdata == pad_oe);

  assert_periph_never_on_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_in & pad_oe) == '0);

  assert_reserved_op_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_op == 2'b11) |=> ($stable(pad_out) && $stable(pad_oe)));

  assert_bitop_misdirected_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_op != 2'b00 && (bus_addr == DIR_ADDR || bus_addr == IEN_ADDR))
      |=> $stable(pad_oe));

  assert_one_write_event: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_data_norm, wr_set, wr_clr, wr_dir, wr_ien}));
endmodule

bind gpio_byte_port gpio_byte_port_checker #(
  .WIDTH(WIDTH), .ADDR_W(ADDR_W), .DIR_ADDR(DIR_ADDR), .IEN_ADDR(IEN_ADDR)
) u_checker (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_wr(bus_wr), .bus_op(bus_op), .bus_bit(bus_bit), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe), .periph_in(periph_in),
  .wr_data_norm(wr_data_norm), .wr_set(wr_set), .wr_clr(wr_clr),
  .wr_dir(wr_dir), .wr_ien(wr_ien)
);

// File: tb/gpio_byte_port_bench.sv
module gpio_byte_port_bench;
  localparam logic [7:0] A_DATA = 8'h25;
  localparam logic [7:0] A_DIR  = 8'h26;
  localparam logic [7:0] A_IEN  = 8'h27;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] bus_addr = '0, bus_wdata = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0] bus_op = '0;
  logic [2:0] bus_bit = '0;
  logic [7:0] bus_rdata, pad_out, pad_oe, periph_in;
  logic [7:0] ext_lvl = '0;
  logic [7:0] pad_in;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  // Resolved pad: driven bits follow the latch, released bits follow the outside.
  assign pad_in = (pad_oe & pad_out) | (~pad_oe & ext_lvl);

  gpio_byte_port u_gpio_byte_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_op(bus_op), .bus_bit(bus_bit), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .pad_out(pad_out), .pad_oe(pad_oe),
    .pad_in(pad_in), .periph_in(periph_in)
  );

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [7:0] d, logic [1:0] op, logic [2:0] b);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_op = op; bus_bit = b; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_op = 2'b00;
  endtask

  task automatic rd(logic [7:0] a, output logic [7:0] v);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 periph_in", periph_in, 8'h00);
    rd(A_DIR, v); check("R1 dir", v, 8'h00);
    rd(A_IEN, v); check("R1 ien", v, 8'h00);

    // R2 R3 R4: sweep latch and direction; released pins read the inverse level
    for (int d = 0; d < 256; d++) begin
      logic [7:0] dat, dir;
      dat = 8'(d);
      dir = dat ^ 8'h5A;
      ext_lvl = ~dat;
      wr(A_DATA, dat, 2'b00, 3'd0);
      check("R3 pad_out", pad_out, dat);
      wr(A_DIR, dir, 2'b00, 3'd0);
      check("R2 pad_oe", pad_oe, dir);
      settle();
      rd(A_DATA, v); check("R4 pin read", v, (dat & dir) | (ext_lvl & ~dir));
    end

    // R4: synchronizer latency, exactly two edges
    wr(A_DIR, 8'h00, 2'b00, 3'd0);
    ext_lvl = 8'h00; settle();
    ext_lvl = 8'hFF;
    @(negedge clk); rd(A_DATA, v); check("R4 after one edge", v, 8'h00);
    @(negedge clk); rd(A_DATA, v); check("R4 after two edges", v, 8'hFF);

    // R5 R6: bit operations with every pin an input at the inverse level
    for (int p = 0; p < 16; p++) begin
      for (int b = 0; b < 8; b++) begin
        for (int o = 1; o <= 2; o++) begin
          logic [7:0] base, exp;
          base = 8'(p * 8'h1D + 8'h33);
          wr(A_DIR, 8'h00, 2'b00, 3'd0);
          wr(A_DATA, base, 2'b00, 3'd0);
          ext_lvl = ~base; settle();
          wr(A_DATA, 8'h00, 2'(o), 3'(b));
          exp = (o == 1) ? (base | (8'd1 << b)) : (base & ~(8'd1 << b));
          if (o == 1) check("R5 set bit", pad_out, exp);
          else        check("R6 clear bit", pad_out, exp);
        end
      end
    end
    // R5: latch visible through the pins once driven
    wr(A_DATA, 8'hA0, 2'b00, 3'd0);
    ext_lvl = 8'h0F;
    wr(A_DATA, 8'h00, 2'b01, 3'd1);
    wr(A_DIR, 8'hFF, 2'b00, 3'd0); settle();
    rd(A_DATA, v); check("R5 driven readback", v, 8'hA2);

    // R7 R8: peripheral gate over direction and enable combinations
    for (int i = 0; i < 256; i++) begin
      logic [7:0] dir, ien;
      dir = 8'(i);
      ien = 8'(i) ^ 8'hC3;
      wr(A_DATA, 8'hFF, 2'b00, 3'd0);
      ext_lvl = 8'(i * 7) ^ 8'h96;
      wr(A_DIR, dir, 2'b00, 3'd0);
      wr(A_IEN, ien, 2'b00, 3'd0);
      settle();
      check("R8 periph_in", periph_in, ext_lvl & ~dir & ien);
      if (i % 16 == 0) begin
        rd(A_DIR, v); check("R7 dir read", v, dir);
        rd(A_IEN, v); check("R7 ien read", v, ien);
      end
    end

    // R9: reserved op, unmapped address, idle read bus
    wr(A_DATA, 8'h3C, 2'b00, 3'd0);
    wr(A_DIR, 8'h81, 2'b00, 3'd0);
    wr(A_IEN, 8'h42, 2'b00, 3'd0);
    wr(A_DATA, 8'hC3, 2'b11, 3'd2);
    check("R9 reserved op latch", pad_out, 8'h3C);
    wr(A_DIR, 8'h7E, 2'b11, 3'd0);
    check("R9 reserved op dir", pad_oe, 8'h81);
    wr(8'h28, 8'hFF, 2'b00, 3'd0);
    wr(8'h24, 8'hFF, 2'b01, 3'd0);
    check("R9 unmapped latch", pad_out, 8'h3C);
    check("R9 unmapped dir", pad_oe, 8'h81);
    rd(A_IEN, v); check("R9 unmapped ien", v, 8'h42);
    rd(8'h28, v); check("R9 unmapped read", v, 8'h00);
    bus_addr = A_DIR; #1 check("R9 idle rdata", bus_rdata, 8'h00);

    // R10: bit operations aimed at the direction and enable registers
    wr(A_DIR, 8'h00, 2'b01, 3'd3);
    wr(A_IEN, 8'h00, 2'b10, 3'd1);
    check("R10 dir untouched", pad_oe, 8'h81);
    rd(A_IEN, v); check("R10 ien untouched", v, 8'h42);
    check("R10 latch untouched", pad_out, 8'h3C);

    finished = 1;
  end

  initial begin
    fork
      begin wait (finished); end
      begin
        repeat (200000) @(posedge clk);
        n_checks++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule